// File: doc/BRIEF.md
# Privileged Control Register Bank

This block holds the 64-bit control and status registers that privileged code reaches through a register index. One write port and one read port each name an index. The decode gives every index its own behaviour. A write may store the whole word, store it through a fixed mask, clear the register whatever the data, be accepted with no stored effect, fire a command strobe, or fault. A read may return the stored word, return a word built partly from a live cycle counter, return a live hardware value, or fault.

Reads are registered. The data and the read fault flag appear in the cycle after the request, and the read sees the state from before any write made in the same cycle. Write faults and command strobes are also one-cycle pulses in the cycle after the write. Two exception-logging registers collect hardware events that are ORed in sticky. Software clears them with any write. A read-only group returns four live hardware words. The invalidate commands for the external translation buffers leave the block only as strobes.

Top module: `ctl_reg_bank`

## Requirements
- R1: After reset every stored register reads zero, and `rd_data_o`, `rd_fault_o`, `wr_fault_o` and `inv_strobe_o` are all zero.
- R2: Indices 0 to 7 (scratch) and index 21 store a full 64-bit write and read it back unchanged, with no fault.
- R3: Index 8 (exception address) stores the write data with bit 1 forced to zero.
- R4: Index 9 and index 10 keep bits [3:0]. Index 11 keeps bits [4:0]. Index 12 and index 13 keep only bits [4:3] (mask 0x18).
- R5: Index 14 keeps mask 0x7fff0, index 15 and index 16 keep mask 0x3f, and index 17 keeps mask 0x7f0.
- R6: Index 18 and index 19 capture `exc_sum_evt_i` and `exc_msk_evt_i` sticky (ORed in every cycle). Any write clears the register to zero, whatever the data. An event arriving in the same cycle as the clearing write is kept.
- R7: A read of index 20 returns stored bits [63:32] joined with the value of `cycle_cnt_i` in the cycle of the request. A write to index 20 stores all 64 bits.
- R8: Indices 24 to 27 are read-only. A read returns 64-bit slice k of `ro_data_i` for index 24+k. A write raises `wr_fault_o` and changes no stored register.
- R9: Indices 28 to 31 are write-only. A write is accepted with no fault and no visible effect. A read raises `rd_fault_o` and returns zero.
- R10: A write to index 32+k (k = 0 to 3) raises `inv_strobe_o[k]` for exactly one cycle and no fault. A read of these indices faults and returns zero.
- R11: Indices 22, 23 and 36 to 63 fault on both read and write, and a faulting read returns zero.
- R12: Read data and `rd_fault_o` appear one cycle after `rd_en_i`, and read zero in other cycles. A read in the same cycle as a write to the same index returns the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_en_i | input | 1 | Read request |
| rd_idx_i | input | 6 | Read register index |
| rd_data_o | output | 64 | Read data, one cycle after the request |
| rd_fault_o | output | 1 | Illegal read pulse, aligned with `rd_data_o` |
| wr_en_i | input | 1 | Write request |
| wr_idx_i | input | 6 | Write register index |
| wr_data_i | input | 64 | Write data |
| wr_fault_o | output | 1 | Illegal write pulse, one cycle after the write |
| cycle_cnt_i | input | 32 | Low half of the free-running cycle counter |
| ro_data_i | input | 256 | Four live words for the read-only indices |
| exc_sum_evt_i | input | 64 | Event bits ORed into index 18 |
| exc_msk_evt_i | input | 64 | Event bits ORed into index 19 |
| inv_strobe_o | output | 4 | One-cycle invalidate command strobes |

## Verification
A wrong mask or a wrong write class per index leaves a bad stored value. That value is invisible until the index is read back, so every write is followed at once by a read. Each error then shows at the ports two cycles after the write. A decode error that shifts the class of an index (fault against store, strobe against accept) shows one cycle after the access as a wrong `wr_fault_o`, `rd_fault_o` or strobe pulse. Aliasing between indices shows as a changed scratch value after writes to other indices. The same-cycle read/write and event/clear orderings are driven directly, because a wrong priority there is otherwise masked.

// File: rtl/ctl_reg_pkg.sv
package ctl_reg_pkg;

  localparam int XLEN        = 64;
  localparam int IDX_W       = 6;
  localparam int CNT_W       = 32;
  localparam int NUM_SCRATCH = 8;
  localparam int NUM_STORED  = 22;
  localparam int RO_BASE     = 24;
  localparam int NUM_RO      = 4;
  localparam int WO_BASE     = 28;
  localparam int NUM_WO      = 4;
  localparam int CMD_BASE    = 32;
  localparam int NUM_CMD     = 4;

  localparam logic [IDX_W-1:0] IX_EXC_ADDR = 6'd8;
  localparam logic [IDX_W-1:0] IX_TRAP_REQ = 6'd9;
  localparam logic [IDX_W-1:0] IX_TRAP_EN  = 6'd10;
  localparam logic [IDX_W-1:0] IX_INT_LVL  = 6'd11;
  localparam logic [IDX_W-1:0] IX_IMODE    = 6'd12;
  localparam logic [IDX_W-1:0] IX_DMODE    = 6'd13;
  localparam logic [IDX_W-1:0] IX_SWINT    = 6'd14;
  localparam logic [IDX_W-1:0] IX_CMODE0   = 6'd15;
  localparam logic [IDX_W-1:0] IX_CMODE1   = 6'd16;
  localparam logic [IDX_W-1:0] IX_IASN     = 6'd17;
  localparam logic [IDX_W-1:0] IX_EXC_SUM  = 6'd18;
  localparam logic [IDX_W-1:0] IX_EXC_MSK  = 6'd19;
  localparam logic [IDX_W-1:0] IX_CYCLE    = 6'd20;
  localparam logic [IDX_W-1:0] IX_PERF     = 6'd21;

  typedef enum logic [1:0] {WK_STORE, WK_ACCEPT, WK_CMD, WK_FAULT} wkind_e;
  typedef enum logic [1:0] {RK_STORED, RK_CYCLE, RK_LIVE, RK_FAULT} rkind_e;

  typedef struct packed {
    wkind_e            wk;
    rkind_e            rk;
    logic [XLEN-1:0]   wmask;
  } idx_attr_t;

  function automatic idx_attr_t attr_of(input logic [IDX_W-1:0] idx);
    idx_attr_t a;
    int unsigned n;
    n       = int'(idx);
    a.wk    = WK_FAULT;
    a.rk    = RK_FAULT;
    a.wmask = '0;
    if (n < NUM_SCRATCH || idx == IX_PERF || idx == IX_CYCLE) begin
      a.wk    = WK_STORE;
      a.rk    = (idx == IX_CYCLE) ? RK_CYCLE : RK_STORED;
      a.wmask = '1;
    end else if (n < NUM_STORED) begin
      a.wk = WK_STORE;
      a.rk = RK_STORED;
      case (idx)
        IX_EXC_ADDR:             a.wmask = ~64'h2;
        IX_TRAP_REQ, IX_TRAP_EN: a.wmask = 64'hF;
        IX_INT_LVL:              a.wmask = 64'h1F;
        IX_IMODE, IX_DMODE:      a.wmask = 64'h18;
        IX_SWINT:                a.wmask = 64'h7FFF0;
        IX_CMODE0, IX_CMODE1:    a.wmask = 64'h3F;
        IX_IASN:                 a.wmask = 64'h7F0;
        default:                 a.wmask = '0;
      endcase
    end else if (n >= RO_BASE && n < RO_BASE + NUM_RO) begin
      a.rk = RK_LIVE;
    end else if (n >= WO_BASE && n < WO_BASE + NUM_WO) begin
      a.wk = WK_ACCEPT;
    end else if (n >= CMD_BASE && n < CMD_BASE + NUM_CMD) begin
      a.wk = WK_CMD;
    end
    return a;
  endfunction

endpackage

// File: rtl/ctl_reg_rst_sync.sv
module ctl_reg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/ctl_reg_decode.sv
module ctl_reg_decode
  import ctl_reg_pkg::*;
(
  input  logic [IDX_W-1:0] rd_idx_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  output rkind_e           rd_kind_o,
  output wkind_e           wr_kind_o,
  output logic [XLEN-1:0]  wr_mask_o
);
  idx_attr_t rd_attr;
  idx_attr_t wr_attr;

  always_comb begin
    rd_attr   = attr_of(rd_idx_i);
    wr_attr   = attr_of(wr_idx_i);
    rd_kind_o = rd_attr.rk;
    wr_kind_o = wr_attr.wk;
    wr_mask_o = wr_attr.wmask;
  end
endmodule

// File: rtl/ctl_reg_store.sv
module ctl_reg_store
  import ctl_reg_pkg::*;
(
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              wr_en_i,
  input  logic [IDX_W-1:0]                  wr_idx_i,
  input  logic [XLEN-1:0]                   wr_data_i,
  input  wkind_e                            wr_kind_i,
  input  logic [XLEN-1:0]                   wr_mask_i,
  input  logic [XLEN-1:0]                   sum_evt_i,
  input  logic [XLEN-1:0]                   msk_evt_i,
  output logic [NUM_STORED-1:0][XLEN-1:0]   regs_o
);

  for (genvar i = 0; i < NUM_STORED; i++) begin : g_reg
    logic            hit;
    logic            en;
    logic [XLEN-1:0] evt;
    logic [XLEN-1:0] d;
    logic [XLEN-1:0] q_r;

    if (i == int'(IX_EXC_SUM)) begin : g_sum
      assign evt = sum_evt_i;
    end else if (i == int'(IX_EXC_MSK)) begin : g_msk
      assign evt = msk_evt_i;
    end else begin : g_none
      assign evt = '0;
    end

    always_comb begin
      hit = wr_en_i && (wr_idx_i == IDX_W'(i)) && (wr_kind_i == WK_STORE);
      en  = hit || (|evt);
      d   = (hit ? (wr_data_i & wr_mask_i) : q_r) | evt;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  q_r <= '0;
      else if (en)  q_r <= d;
    end

    assign regs_o[i] = q_r;
  end

  // R8: a faulting write with no event in flight leaves every register as it was
  p_fault_keeps_state_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_kind_i == WK_FAULT && sum_evt_i == '0 && msk_evt_i == '0)
      |=> $stable(regs_o));

  // R6: after a write to the summary register only same-cycle events remain
  p_exc_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_idx_i == IX_EXC_SUM)
      |=> (regs_o[IX_EXC_SUM] == $past(sum_evt_i)));

endmodule

// File: rtl/ctl_reg_bank.sv
module ctl_reg_bank
  import ctl_reg_pkg::*;
(
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      rd_en_i,
  input  logic [IDX_W-1:0]          rd_idx_i,
  output logic [XLEN-1:0]           rd_data_o,
  output logic                      rd_fault_o,
  input  logic                      wr_en_i,
  input  logic [IDX_W-1:0]          wr_idx_i,
  input  logic [XLEN-1:0]           wr_data_i,
  output logic                      wr_fault_o,
  input  logic [CNT_W-1:0]          cycle_cnt_i,
  input  logic [NUM_RO*XLEN-1:0]    ro_data_i,
  input  logic [XLEN-1:0]           exc_sum_evt_i,
  input  logic [XLEN-1:0]           exc_msk_evt_i,
  output logic [NUM_CMD-1:0]        inv_strobe_o
);

  logic                            rst_n;
  rkind_e                          rd_kind;
  wkind_e                          wr_kind;
  logic [XLEN-1:0]                 wr_mask;
  logic [NUM_STORED-1:0][XLEN-1:0] regs;

  logic [XLEN-1:0]    stored_sel, live_sel, rd_val;
  logic [XLEN-1:0]    rd_data_d, rd_data_q;
  logic               rd_fault_d, rd_fault_q;
  logic               wr_fault_d, wr_fault_q;
  logic [NUM_CMD-1:0] strobe_d, strobe_q;

  ctl_reg_rst_sync #(.STAGES(2)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  ctl_reg_decode u_dec (
    .rd_idx_i  (rd_idx_i),
    .wr_idx_i  (wr_idx_i),
    .rd_kind_o (rd_kind),
    .wr_kind_o (wr_kind),
    .wr_mask_o (wr_mask)
  );

  ctl_reg_store u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_idx_i  (wr_idx_i),
    .wr_data_i (wr_data_i),
    .wr_kind_i (wr_kind),
    .wr_mask_i (wr_mask),
    .sum_evt_i (exc_sum_evt_i),
    .msk_evt_i (exc_msk_evt_i),
    .regs_o    (regs)
  );

  // read selection
  always_comb begin
    stored_sel = '0;
    for (int i = 0; i < NUM_STORED; i++)
      if (rd_idx_i == IDX_W'(i)) stored_sel = regs[i];
    live_sel = '0;
    for (int k = 0; k < NUM_RO; k++)
      if (rd_idx_i == IDX_W'(RO_BASE + k)) live_sel = ro_data_i[k*XLEN +: XLEN];
    case (rd_kind)
      RK_STORED: rd_val = stored_sel;
      RK_CYCLE:  rd_val = {regs[IX_CYCLE][XLEN-1:CNT_W], cycle_cnt_i};
      RK_LIVE:   rd_val = live_sel;
      default:   rd_val = '0;
    endcase
  end

  // next state of the output pulses
  always_comb begin
    rd_data_d  = rd_en_i ? rd_val : '0;
    rd_fault_d = rd_en_i && (rd_kind == RK_FAULT);
    wr_fault_d = wr_en_i && (wr_kind == WK_FAULT);
    for (int k = 0; k < NUM_CMD; k++)
      strobe_d[k] = wr_en_i && (wr_kind == WK_CMD) && (wr_idx_i == IDX_W'(CMD_BASE + k));
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      rd_data_q  <= '0;
      rd_fault_q <= 1'b0;
      wr_fault_q <= 1'b0;
      strobe_q   <= '0;
    end else begin
      rd_data_q  <= rd_data_d;
      rd_fault_q <= rd_fault_d;
      wr_fault_q <= wr_fault_d;
      strobe_q   <= strobe_d;
    end
  end

  assign rd_data_o    = rd_data_q;
  assign rd_fault_o   = rd_fault_q;
  assign wr_fault_o   = wr_fault_q;
  assign inv_strobe_o = strobe_q;

  // R9: a faulting read never carries data
  p_fault_zero_data_r9: assert property (@(posedge clk_i) disable iff (!rst_n)
    rd_fault_o |-> (rd_data_o == '0));

  // R10: at most one command strobe at a time
  p_strobe_onehot_r10: assert property (@(posedge clk_i) disable iff (!rst_n)
    $onehot0(inv_strobe_o));

  // R10: the first invalidate index pulses strobe bit 0 next cycle
  p_strobe_cmd0_r10: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_en_i && wr_idx_i == IDX_W'(CMD_BASE)) |=> inv_strobe_o[0] && !wr_fault_o);

  // R11: indices above the command group fault on read
  p_undef_read_r11: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rd_en_i && int'(rd_idx_i) >= CMD_BASE + NUM_CMD) |=> rd_fault_o);

  // R7: low half of the cycle read follows the counter of the request cycle
  p_cycle_low_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rd_en_i && rd_idx_i == IX_CYCLE) |=> (rd_data_o[CNT_W-1:0] == $past(cycle_cnt_i)));

  // R12: no read request, no read fault and no data
  p_idle_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_n)
    !rd_en_i |=> (!rd_fault_o && rd_data_o == '0));

endmodule

// File: tb/ctl_reg_bank_tb.sv
module ctl_reg_bank_tb_top;
  import ctl_reg_pkg::*;

  logic                   clk = 1'b0;
  logic                   rst_ni;
  logic                   rd_en_i, wr_en_i;
  logic [IDX_W-1:0]       rd_idx_i, wr_idx_i;
  logic [XLEN-1:0]        wr_data_i, rd_data_o;
  logic                   rd_fault_o, wr_fault_o;
  logic [CNT_W-1:0]       cycle_cnt_i;
  logic [NUM_RO*XLEN-1:0] ro_data_i;
  logic [XLEN-1:0]        exc_sum_evt_i, exc_msk_evt_i;
  logic [NUM_CMD-1:0]     inv_strobe_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  ctl_reg_bank dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .rd_en_i(rd_en_i), .rd_idx_i(rd_idx_i), .rd_data_o(rd_data_o), .rd_fault_o(rd_fault_o),
    .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i), .wr_fault_o(wr_fault_o),
    .cycle_cnt_i(cycle_cnt_i), .ro_data_i(ro_data_i),
    .exc_sum_evt_i(exc_sum_evt_i), .exc_msk_evt_i(exc_msk_evt_i),
    .inv_strobe_o(inv_strobe_o)
  );

  typedef struct packed {
    logic [5:0]  idx;
    logic [63:0] wd;
    logic [63:0] exp;
    logic        wf;
    logic        rf;
    logic [7:0]  req;
  } vec_t;

  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{6'd0,  64'h0123456789ABCDEF, 64'h0123456789ABCDEF, 1'b0, 1'b0, 8'd2},  // R2
    '{6'd7,  64'hFEDCBA9876543210, 64'hFEDCBA9876543210, 1'b0, 1'b0, 8'd2},  // R2
    '{6'd21, 64'hDEADBEEFCAFEF00D, 64'hDEADBEEFCAFEF00D, 1'b0, 1'b0, 8'd2},  // R2
    '{6'd8,  ONES,                 64'hFFFFFFFFFFFFFFFD, 1'b0, 1'b0, 8'd3},  // R3
    '{6'd8,  64'h7,                64'h5,                1'b0, 1'b0, 8'd3},  // R3
    '{6'd9,  ONES,                 64'hF,                1'b0, 1'b0, 8'd4},  // R4
    '{6'd10, 64'hF0F5,             64'h5,                1'b0, 1'b0, 8'd4},  // R4
    '{6'd11, ONES,                 64'h1F,               1'b0, 1'b0, 8'd4},  // R4
    '{6'd12, ONES,                 64'h18,               1'b0, 1'b0, 8'd4},  // R4
    '{6'd13, 64'hF,                64'h8,                1'b0, 1'b0, 8'd4},  // R4
    '{6'd14, ONES,                 64'h7FFF0,            1'b0, 1'b0, 8'd5},  // R5
    '{6'd15, ONES,                 64'h3F,               1'b0, 1'b0, 8'd5},  // R5
    '{6'd16, 64'hC0,               64'h0,                1'b0, 1'b0, 8'd5},  // R5
    '{6'd17, ONES,                 64'h7F0,              1'b0, 1'b0, 8'd5},  // R5
    '{6'd18, ONES,                 64'h0,                1'b0, 1'b0, 8'd6},  // R6
    '{6'd19, ONES,                 64'h0,                1'b0, 1'b0, 8'd6},  // R6
    '{6'd24, ONES,                 64'h1111111111111111, 1'b1, 1'b0, 8'd8},  // R8
    '{6'd27, ONES,                 64'h4444444444444444, 1'b1, 1'b0, 8'd8},  // R8
    '{6'd28, ONES,                 64'h0,                1'b0, 1'b1, 8'd9},  // R9
    '{6'd31, ONES,                 64'h0,                1'b0, 1'b1, 8'd9},  // R9
    '{6'd35, ONES,                 64'h0,                1'b0, 1'b1, 8'd10}, // R10
    '{6'd22, ONES,                 64'h0,                1'b1, 1'b1, 8'd11}, // R11
    '{6'd40, ONES,                 64'h0,                1'b1, 1'b1, 8'd11}, // R11
    '{6'd63, ONES,                 64'h0,                1'b1, 1'b1, 8'd11}  // R11
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [5:0] idx, input logic [63:0] wd, input logic wf, input string req);
    @(negedge clk);
    wr_en_i = 1'b1; wr_idx_i = idx; wr_data_i = wd;
    @(negedge clk);
    wr_en_i = 1'b0;
    check(wr_fault_o == wf, req, 64'(wr_fault_o), 64'(wf));
  endtask

  task automatic do_read(input logic [5:0] idx, input logic [63:0] exp, input logic rf, input string req);
    @(negedge clk);
    rd_en_i = 1'b1; rd_idx_i = idx;
    @(negedge clk);
    rd_en_i = 1'b0;
    check(rd_data_o == exp, req, rd_data_o, exp);
    check(rd_fault_o == rf, req, 64'(rd_fault_o), 64'(rf));
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; rd_en_i = 1'b0; wr_en_i = 1'b0;
    rd_idx_i = '0; wr_idx_i = '0; wr_data_i = '0;
    cycle_cnt_i = 32'h0;
    ro_data_i = {64'h4444444444444444, 64'h3333333333333333,
                 64'h2222222222222222, 64'h1111111111111111};
    exc_sum_evt_i = '0; exc_msk_evt_i = '0;
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    check(rd_data_o == '0 && !rd_fault_o && !wr_fault_o && inv_strobe_o == '0,
          "R1", rd_data_o, 64'h0);
    do_read(6'd0,  64'h0, 1'b0, "R1");
    do_read(6'd12, 64'h0, 1'b0, "R1");
    do_read(6'd18, 64'h0, 1'b0, "R1");

    // vector table: write then read back each index
    for (int i = 0; i < NV; i++) begin
      do_write(VECS[i].idx, VECS[i].wd, VECS[i].wf, $sformatf("R%0d", VECS[i].req));
      do_read(VECS[i].idx, VECS[i].exp, VECS[i].rf, $sformatf("R%0d", VECS[i].req));
    end

    // R8: read-only writes did not disturb stored registers, live words readable
    do_write(6'd26, ONES, 1'b1, "R8");
    do_read(6'd0,  64'h0123456789ABCDEF, 1'b0, "R8");
    do_read(6'd26, 64'h3333333333333333, 1'b0, "R8");

    // R7: cycle register composition
    do_write(6'd20, 64'hAAAABBBBCCCCDDDD, 1'b0, "R7");
    cycle_cnt_i = 32'h33334444;
    do_read(6'd20, 64'hAAAABBBB33334444, 1'b0, "R7");
    cycle_cnt_i = 32'h0000FFFF;
    do_read(6'd20, 64'hAAAABBBB0000FFFF, 1'b0, "R7");

    // R10: strobe one cycle wide, on bit k
    @(negedge clk);
    wr_en_i = 1'b1; wr_idx_i = 6'd34; wr_data_i = ONES;
    @(negedge clk);
    wr_en_i = 1'b0;
    check(inv_strobe_o == 4'b0100 && !wr_fault_o, "R10", 64'(inv_strobe_o), 64'h4);
    @(negedge clk);
    check(inv_strobe_o == 4'b0000, "R10", 64'(inv_strobe_o), 64'h0);

    // R6: sticky event capture, clear by write, same-cycle event kept
    @(negedge clk);
    exc_sum_evt_i = 64'h5;
    @(negedge clk);
    exc_sum_evt_i = '0;
    do_read(6'd18, 64'h5, 1'b0, "R6");
    @(negedge clk);
    exc_msk_evt_i = 64'h30;
    @(negedge clk);
    exc_msk_evt_i = '0;
    do_read(6'd19, 64'h30, 1'b0, "R6");
    @(negedge clk);
    wr_en_i = 1'b1; wr_idx_i = 6'd18; wr_data_i = ONES; exc_sum_evt_i = 64'h8;
    @(negedge clk);
    wr_en_i = 1'b0; exc_sum_evt_i = '0;
    do_read(6'd18, 64'h8, 1'b0, "R6");
    do_write(6'd19, 64'h0, 1'b0, "R6");
    do_read(6'd19, 64'h0, 1'b0, "R6");

    // R12: read and write of the same index in one cycle returns old data
    @(negedge clk);
    wr_en_i = 1'b1; wr_idx_i = 6'd1; wr_data_i = 64'h5A5A5A5A12345678;
    rd_en_i = 1'b1; rd_idx_i = 6'd1;
    @(negedge clk);
    wr_en_i = 1'b0; rd_en_i = 1'b0;
    check(rd_data_o == 64'h0, "R12", rd_data_o, 64'h0);
    @(negedge clk);
    check(rd_data_o == 64'h0 && !rd_fault_o, "R12", rd_data_o, 64'h0);
    do_read(6'd1, 64'h5A5A5A5A12345678, 1'b0, "R12");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule